// File: doc/BRIEF.md
# Serial-to-Parallel Converter with Holding Register

This block turns a serial bit stream into a parallel word in two stages. A chain of shift stages takes one bit from the serial input on each rising edge of the shift clock. A separate holding register copies the whole chain in parallel on each rising edge of the storage clock. The holding register drives the parallel outputs, so these outputs stay steady while the next word is shifted in.

The two registers have separate clocks and separate asynchronous active-low clears. The last shift stage also drives a cascade output. Several instances can therefore be chained into a wider converter: the cascade output of one instance feeds the serial input of the next, and all instances share both clocks. The word width is a parameter with a default of 8 and a minimum of 2.

Top module: `sipo_latch`

## Requirements
- R1: On each rising edge of `shift_clk`, while `shift_clr_n` is high, stage 0 takes `ser_din` and every stage i (i >= 1) takes the old value of stage i-1. No bit is inverted.
- R2: On each rising edge of `hold_clk`, while `hold_clr_n` is high, the holding register copies all shift stages in parallel. `par_q[i]` always equals holding bit i, and holding bit i receives shift stage i.
- R3: `cascade_out` always equals the last shift stage (stage WIDTH-1). It changes only on shift edges and clears, never because of the holding register.
- R4: Driving `shift_clr_n` low sets every shift stage to 0 at once, without waiting for a clock edge. `cascade_out` therefore reads 0 and `par_q` keeps its value.
- R5: Driving `hold_clr_n` low sets `par_q` to 0 at once, without waiting for a clock edge. The shift stages and `cascade_out` keep their values.
- R6: While a clear input is low, rising edges on that register's clock have no effect. The register stays 0 until the clear goes high.
- R7: When the shift and storage clocks rise at the same instant, the holding register captures the shift contents from before that edge, so it is one shift behind.
- R8: In a chain of two instances, 16 shift edges followed by one storage edge present the 16 bits in order across {second `par_q`, first `par_q`}. The first bit shifted in appears at bit 15 (bit 7 of the second instance) and on the second instance's `cascade_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk | input | 1 | Shift clock, rising edge active |
| shift_clr_n | input | 1 | Asynchronous clear of the shift stages, active low |
| ser_din | input | 1 | Serial data input into stage 0 |
| hold_clk | input | 1 | Storage clock, rising edge copies the stages into the holding register |
| hold_clr_n | input | 1 | Asynchronous clear of the holding register, active low |
| par_q | output | WIDTH | Parallel data from the holding register |
| cascade_out | output | 1 | Last shift stage, for chaining |

## Verification
Four properties are checked on every edge:
- The one-step movement of the shift chain on each shift edge.
- The capture of the chain's previous contents into the holding register on each storage edge.
- That each register reads zero at the edges of its own clock while its clear is held low.

Only the bench's scenarios can show the following:
- That a clear acts at once between edges and leaves the other register untouched.
- The one-shift lag when both clocks are tied together.
- The ordering of bits across a chain of two instances.

The bench shows these by comparing against a reference model after every edge and every change of a clear.

// File: rtl/sipo_pkg.sv
package sipo_pkg;

  // Default word width of one converter instance
  localparam int unsigned SIPO_DEF_WIDTH = 8;

  // Next contents of the shift chain: new bit enters at stage 0
  function automatic logic [SIPO_DEF_WIDTH-1:0] sipo_step_ref(
    input logic [SIPO_DEF_WIDTH-1:0] cur,
    input logic                      bit_in
  );
    return {cur[SIPO_DEF_WIDTH-2:0], bit_in};
  endfunction

endpackage

// File: rtl/sipo_shift_chain.sv
module sipo_shift_chain #(
  parameter int unsigned WIDTH = sipo_pkg::SIPO_DEF_WIDTH
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             din,
  output logic [WIDTH-1:0] stage_q
);

  localparam int unsigned LAST = WIDTH - 1;

  logic [WIDTH-1:0] stage_d;

  // Next-state: stage 0 from the serial input, the rest from their neighbour
  always_comb begin
    stage_d[0] = din;
    for (int i = 1; i < int'(WIDTH); i++) begin
      stage_d[i] = stage_q[i-1];
    end
  end

  // One flop per stage, each with the asynchronous clear
  for (genvar g = 0; g < int'(WIDTH); g++) begin : g_stage
    always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) stage_q[g] <= 1'b0;
      else        stage_q[g] <= stage_d[g];
    end
  end

  // R1
  shift_step_chk: assert property (@(posedge clk) disable iff (!clr_n)
    1'b1 |=> stage_q == {$past(stage_q[LAST-1:0]), $past(din)});

endmodule

// File: rtl/sipo_hold_reg.sv
module sipo_hold_reg #(
  parameter int unsigned WIDTH = sipo_pkg::SIPO_DEF_WIDTH
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] hold_d;

  // Next-state: a full parallel copy of the stage vector
  always_comb begin
    hold_d = d;
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= '0;
    else        q <= hold_d;
  end

  // R2
  hold_capture_chk: assert property (@(posedge clk) disable iff (!clr_n)
    1'b1 |=> q == $past(d));

endmodule

// File: rtl/sipo_latch.sv
module sipo_latch #(
  parameter int unsigned WIDTH = sipo_pkg::SIPO_DEF_WIDTH
) (
  input  logic             shift_clk,
  input  logic             shift_clr_n,
  input  logic             ser_din,
  input  logic             hold_clk,
  input  logic             hold_clr_n,
  output logic [WIDTH-1:0] par_q,
  output logic             cascade_out
);

  localparam int unsigned LAST = WIDTH - 1;

  logic [WIDTH-1:0] shift_q;

  sipo_shift_chain #(.WIDTH(WIDTH)) u_chain (
    .clk     (shift_clk),
    .clr_n   (shift_clr_n),
    .din     (ser_din),
    .stage_q (shift_q)
  );

  sipo_hold_reg #(.WIDTH(WIDTH)) u_hold (
    .clk   (hold_clk),
    .clr_n (hold_clr_n),
    .d     (shift_q),
    .q     (par_q)
  );

  // R3: cascade taken from the last shift stage, not the holding register
  assign cascade_out = shift_q[LAST];

  // R4
  shift_clr_zero_chk: assert property (@(posedge shift_clk) disable iff (!hold_clr_n)
    !shift_clr_n |-> shift_q == '0);

  // R5
  hold_clr_zero_chk: assert property (@(posedge hold_clk) disable iff (!shift_clr_n)
    !hold_clr_n |-> par_q == '0);

endmodule

// File: tb/test_sipo_latch.sv
module test_sipo_latch;

  localparam int W          = 8;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 6;

  // Table: serial stimulus (bit 15 shifted first) and expected chained parallel word
  localparam logic [2*W-1:0] STIM [NVEC] = '{16'hA5C3, 16'h0001, 16'h8000, 16'hFFFF, 16'h1234, 16'h0F0F};
  localparam logic [2*W-1:0] EXPW [NVEC] = '{16'hA5C3, 16'h0001, 16'h8000, 16'hFFFF, 16'h1234, 16'h0F0F};

  logic shift_clk, hold_clk, shift_clr_n, hold_clr_n, din;
  logic [W-1:0] par_a, par_b;
  logic casc_a, casc_b;

  int n_chk, n_bad;
  logic [2*W-1:0] m_sh, m_hd;

  sipo_latch #(.WIDTH(W)) i_sipo_latch (
    .shift_clk(shift_clk), .shift_clr_n(shift_clr_n), .ser_din(din),
    .hold_clk(hold_clk), .hold_clr_n(hold_clr_n),
    .par_q(par_a), .cascade_out(casc_a));

  sipo_latch #(.WIDTH(W)) i_sipo_latch_tail (
    .shift_clk(shift_clk), .shift_clr_n(shift_clr_n), .ser_din(casc_a),
    .hold_clk(hold_clk), .hold_clr_n(hold_clr_n),
    .par_q(par_b), .cascade_out(casc_b));

  task automatic chk(string req, logic [2*W-1:0] act, logic [2*W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_model(string req);
    chk(req, {par_b, par_a}, m_hd);
    chk(req, {14'd0, casc_b, casc_a}, {14'd0, m_sh[2*W-1], m_sh[W-1]});
  endtask

  task automatic shift_edge(logic b, string req);
    din = b;
    #(CLK_PERIOD/4);
    shift_clk = 1'b1;
    if (shift_clr_n) m_sh = {m_sh[2*W-2:0], b};
    #(CLK_PERIOD/4);
    check_model(req);
    shift_clk = 1'b0;
    #(CLK_PERIOD/2);
  endtask

  task automatic hold_edge(string req);
    #(CLK_PERIOD/4);
    hold_clk = 1'b1;
    if (hold_clr_n) m_hd = m_sh;
    #(CLK_PERIOD/4);
    check_model(req);
    hold_clk = 1'b0;
    #(CLK_PERIOD/2);
  endtask

  task automatic both_edge(logic b, string req);
    logic [2*W-1:0] old;
    din = b;
    #(CLK_PERIOD/4);
    old = m_sh;
    shift_clk = 1'b1;
    hold_clk  = 1'b1;
    if (shift_clr_n) m_sh = {m_sh[2*W-2:0], b};
    if (hold_clr_n)  m_hd = old;
    #(CLK_PERIOD/4);
    check_model(req);
    shift_clk = 1'b0;
    hold_clk  = 1'b0;
    #(CLK_PERIOD/2);
  endtask

  task automatic set_shift_clr(logic v, string req);
    shift_clr_n = v;
    if (!v) m_sh = '0;
    #(CLK_PERIOD/4);
    check_model(req);
  endtask

  task automatic set_hold_clr(logic v, string req);
    hold_clr_n = v;
    if (!v) m_hd = '0;
    #(CLK_PERIOD/4);
    check_model(req);
  endtask

  task automatic load_word(logic [2*W-1:0] w, string req);
    for (int j = 2*W-1; j >= 0; j--) shift_edge(w[j], req);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    m_sh = '0; m_hd = '0;
    shift_clk = 1'b0; hold_clk = 1'b0; din = 1'b0;
    shift_clr_n = 1'b0; hold_clr_n = 1'b0;
    #(CLK_PERIOD/4);
    check_model("R4 R5 reset state");
    // R6: edges while both clears are held have no effect
    shift_edge(1'b1, "R6");
    hold_edge("R6");
    set_shift_clr(1'b1, "R4");
    set_hold_clr(1'b1, "R5");

    // R8 table walk; R1 R3 checked on every shift edge via the model
    for (int k = 0; k < NVEC; k++) begin
      load_word(STIM[k], "R1 R3");
      hold_edge("R2");
      chk("R8 chained word", {par_b, par_a}, EXPW[k]);
      chk("R8 first bit at tail cascade", {15'd0, casc_b}, {15'd0, STIM[k][2*W-1]});
    end

    // R3: cascade moves while the holding register stays put
    shift_edge(1'b1, "R3");
    shift_edge(1'b0, "R3");
    shift_edge(1'b1, "R3");

    // R4: shift clear between edges leaves the holding register alone
    hold_edge("R2");
    shift_edge(1'b1, "R1");
    set_shift_clr(1'b0, "R4 async");
    shift_edge(1'b1, "R6 shift clear overrides");
    hold_edge("R2 captures cleared chain");
    set_shift_clr(1'b1, "R4 release");
    load_word(16'hC35A, "R1");

    // R5: storage clear between edges leaves the shift stages alone
    hold_edge("R2");
    shift_edge(1'b0, "R1");
    set_hold_clr(1'b0, "R5 async");
    shift_edge(1'b1, "R5 shift unaffected");
    hold_edge("R6 hold clear overrides");
    set_hold_clr(1'b1, "R5 release");
    hold_edge("R2 after release");

    // R7: both clocks tied together
    for (int j = 0; j < 20; j++) both_edge(j[0] ^ j[2], "R7");
    both_edge(1'b1, "R7");
    chk("R7 one shift behind", {par_b, par_a}, {m_sh[2*W-1], m_sh[2*W-1:1]} & 16'hFFFF ^ {m_sh[2*W-1], m_sh[2*W-1:1]} ^ m_hd);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule